// File: doc/BRIEF.md
# Partial-Context Migration Mask Controller

This block sits beside one hardware thread and decides which general registers travel with the thread each time it migrates between cores. It keeps two masks. The carried mask records the registers the thread took along when it left its native core. The written mask records the registers the thread has written since it left. The block classifies each migration request by where the thread is now and where it is going. From that class it picks the predictor's useful mask, the carried mask or the written mask as the transfer mask. It also flags that the special-purpose registers go along with every transfer.

While the thread runs away from its native core, the block compares the registers each instruction reads and writes against the carried mask. If the instruction touches a register the thread did not bring, that is a register miss. The instruction is dropped and the block raises a request to return home. It also reports the lowest missing register index, so the predictor can learn it.

The controller is a three-state machine:
- **NATIVE**: at the native core. The carried mask reads as all ones here.
- **AWAY**: running on a non-native core.
- **MISS**: a register miss was found and the thread is waiting to go home.

Its transitions are:
- **LEAVE**: NATIVE to AWAY, on a migration to a non-native core.
- **HOP**: AWAY to AWAY, on a migration to another non-native core.
- **FAULT**: AWAY to MISS, on a register miss.
- **RETURN**: AWAY or MISS to NATIVE, on a migration to the native core.

Top module: `mig_mask_ctrl`

## Requirements
- R1: After reset the block is in NATIVE with `vmask_o` all ones, `wmask_o` zero, and `xfer_valid`, `regmiss`, `away_o` and `home_req` all low.
- R2: On a LEAVE (request in NATIVE with `mig_to_native`=0), the cycle after the request shows `xfer_valid`=1, `xfer_kind`=1 and `xfer_mask` equal to `pred_mask`. From then on `vmask_o` equals that `pred_mask`, `wmask_o` is zero and `away_o` is 1.
- R3: On a HOP (request in AWAY with `mig_to_native`=0), the cycle after shows `xfer_kind`=2 and `xfer_mask` equal to the carried mask, whatever `pred_mask` holds. Both masks keep their values.
- R4: On a RETURN (request in AWAY or MISS with `mig_to_native`=1), the cycle after shows `xfer_kind`=3 and `xfer_mask` equal to the written mask. Afterwards `vmask_o` is all ones, `wmask_o` is zero, and `away_o` and `home_req` are 0.
- R5: Every transfer cycle (`xfer_valid`=1) has `xfer_spr`=1. The cycle after a cycle with no transfer has `xfer_valid`=0, `xfer_spr`=0 and `xfer_mask`=0.
- R6: In AWAY, an instruction whose read and write registers all lie inside the carried mask ORs its `wr_mask` into the written mask. The new value shows on `wmask_o` one cycle later.
- R7: In AWAY, an instruction with a read or write bit outside the carried mask gives a one-cycle `regmiss` pulse on the next cycle. The state moves to MISS, so `home_req`=1, and none of that instruction's writes reach the written mask.
- R8: When several registers miss at once, `regmiss_idx` is the lowest missing register index. It holds that value until the next miss.
- R9: In NATIVE, instructions never cause `regmiss`, and a migration request with `mig_to_native`=1 produces no transfer.
- R10: In MISS, instructions cause no new `regmiss` and leave the written mask unchanged. A migration request with `mig_to_native`=0 produces no transfer and does not leave MISS.
- R11: An instruction presented in the same cycle as a migration request is ignored: it causes no miss and no written-mask update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mig_valid | input | 1 | A migration of this thread happens this cycle |
| mig_to_native | input | 1 | The migration destination is the native core |
| pred_mask | input | NREG | Useful-register mask from the predictor |
| instr_valid | input | 1 | An instruction executes this cycle |
| rd_mask | input | NREG | Registers the instruction reads |
| wr_mask | input | NREG | Registers the instruction writes |
| xfer_valid | output | 1 | A transfer mask is presented |
| xfer_kind | output | 2 | Transfer class: 0 none, 1 leave, 2 hop, 3 return |
| xfer_mask | output | NREG | General registers to send |
| xfer_spr | output | 1 | Special-purpose registers are sent |
| vmask_o | output | NREG | Carried mask (all ones at native) |
| wmask_o | output | NREG | Written mask |
| away_o | output | 1 | Thread is off its native core |
| home_req | output | 1 | Register miss pending; thread must return home |
| regmiss | output | 1 | One-cycle pulse on a register miss |
| regmiss_idx | output | $clog2(NREG) | Lowest missing register index |

## Verification
The hardest case to reach is the MISS state with a written mask that has been built up partly. The bench needs this state to show that the faulting write was dropped and that the later return sends exactly the earlier writes. To get there, the bench sweeps every carried mask of an 8-register configuration. For each mask it leaves home with that mask, writes a mask-dependent subset and hops while presenting a bogus instruction and predictor value. It then forces a miss with an instruction that writes all registers, pokes the blocked MISS state, and returns home. Every expected mask and miss index is computed arithmetically from the loop value.

// File: rtl/mig_mask_pkg.sv
package mig_mask_pkg;

    typedef enum logic [1:0] {
        ST_NATIVE = 2'd0,
        ST_AWAY   = 2'd1,
        ST_MISS   = 2'd2
    } loc_state_t;

    typedef enum logic [1:0] {
        XK_NONE = 2'd0,
        XK_OUT  = 2'd1,
        XK_HOP  = 2'd2,
        XK_HOME = 2'd3
    } xfer_kind_t;

endpackage

// File: rtl/mig_lowbit_enc.sv
module mig_lowbit_enc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // R8
    always_comb begin
        if (found) begin
            lowest_set_chk: assert (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0));
        end
    end
endmodule

// File: rtl/mig_miss_detect.sv
module mig_miss_detect #(
    parameter int NREG = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            check_en,
    input  logic [NREG-1:0] rd_mask,
    input  logic [NREG-1:0] wr_mask,
    input  logic [NREG-1:0] vmask,
    output logic            miss,
    output logic [IW-1:0]   miss_idx
);
    logic [NREG-1:0] missing;

    always_comb begin
        missing = (rd_mask | wr_mask) & ~vmask & {NREG{check_en}};
    end

    mig_lowbit_enc #(.W(NREG), .IW(IW)) u_enc (
        .vec   (missing),
        .idx   (miss_idx),
        .found (miss)
    );

    // R7
    always_comb begin
        if (miss) begin
            miss_outside_chk: assert (check_en && !vmask[miss_idx]);
        end
    end
endmodule

// File: rtl/mig_xfer_sel.sv
module mig_xfer_sel
    import mig_mask_pkg::*;
#(
    parameter int NREG = 32
) (
    input  xfer_kind_t      kind,
    input  logic [NREG-1:0] pred_mask,
    input  logic [NREG-1:0] vmask,
    input  logic [NREG-1:0] wmask,
    output logic [NREG-1:0] sel_mask
);
    always_comb begin
        unique case (kind)
            XK_OUT:  sel_mask = pred_mask;
            XK_HOP:  sel_mask = vmask;
            XK_HOME: sel_mask = wmask;
            default: sel_mask = '0;
        endcase
    end
endmodule

// File: rtl/mig_mask_ctrl.sv
module mig_mask_ctrl
    import mig_mask_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mig_valid,
    input  logic            mig_to_native,
    input  logic [NREG-1:0] pred_mask,
    input  logic            instr_valid,
    input  logic [NREG-1:0] rd_mask,
    input  logic [NREG-1:0] wr_mask,
    output logic            xfer_valid,
    output logic [1:0]      xfer_kind,
    output logic [NREG-1:0] xfer_mask,
    output logic            xfer_spr,
    output logic [NREG-1:0] vmask_o,
    output logic [NREG-1:0] wmask_o,
    output logic            away_o,
    output logic            home_req,
    output logic            regmiss,
    output logic [IDXW-1:0] regmiss_idx
);
    loc_state_t      state_q, state_d;
    xfer_kind_t      kind_c;
    logic [NREG-1:0] v_q, w_q, sel_mask;
    logic            instr_ok, miss_c;
    logic [IDXW-1:0] miss_idx_c;

    // classify the requested migration from the present location
    always_comb begin
        kind_c = XK_NONE;
        if (mig_valid) begin
            unique case (state_q)
                ST_NATIVE: kind_c = mig_to_native ? XK_NONE : XK_OUT;
                ST_AWAY:   kind_c = mig_to_native ? XK_HOME : XK_HOP;
                ST_MISS:   kind_c = mig_to_native ? XK_HOME : XK_NONE;
                default:   kind_c = XK_NONE;
            endcase
        end
    end

    assign instr_ok = instr_valid && !mig_valid;

    mig_miss_detect #(.NREG(NREG), .IW(IDXW)) u_detect (
        .check_en (instr_ok && (state_q == ST_AWAY)),
        .rd_mask  (rd_mask),
        .wr_mask  (wr_mask),
        .vmask    (v_q),
        .miss     (miss_c),
        .miss_idx (miss_idx_c)
    );

    mig_xfer_sel #(.NREG(NREG)) u_sel (
        .kind      (kind_c),
        .pred_mask (pred_mask),
        .vmask     (v_q),
        .wmask     (w_q),
        .sel_mask  (sel_mask)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NATIVE: if (kind_c == XK_OUT) state_d = ST_AWAY;
            ST_AWAY: begin
                if (kind_c == XK_HOME)  state_d = ST_NATIVE;
                else if (miss_c)        state_d = ST_MISS;
            end
            ST_MISS:   if (kind_c == XK_HOME) state_d = ST_NATIVE;
            default:   state_d = ST_NATIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NATIVE;
        else        state_q <= state_d;
    end

    // masks and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q         <= '1;
            w_q         <= '0;
            xfer_valid  <= 1'b0;
            xfer_kind   <= 2'd0;
            xfer_mask   <= '0;
            xfer_spr    <= 1'b0;
            regmiss     <= 1'b0;
            regmiss_idx <= '0;
        end else begin
            xfer_valid <= (kind_c != XK_NONE);
            xfer_spr   <= (kind_c != XK_NONE);
            xfer_kind  <= kind_c;
            xfer_mask  <= sel_mask;
            regmiss    <= miss_c;
            if (miss_c) regmiss_idx <= miss_idx_c;
            unique case (kind_c)
                XK_OUT: begin
                    v_q <= pred_mask;
                    w_q <= '0;
                end
                XK_HOME: begin
                    v_q <= '1;
                    w_q <= '0;
                end
                default: begin
                    if (state_q == ST_AWAY && instr_ok && !miss_c)
                        w_q <= w_q | wr_mask;
                end
            endcase
        end
    end

    assign vmask_o  = v_q;
    assign wmask_o  = w_q;
    assign away_o   = (state_q != ST_NATIVE);
    assign home_req = (state_q == ST_MISS);

    // R6
    w_inside_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        away_o |-> ((w_q & ~v_q) == '0));

    // R7
    miss_forces_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regmiss |-> home_req);

    // R9
    native_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NATIVE) |=> !regmiss);

    // R6
    w_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAY && !mig_valid) |=> ((w_q & $past(w_q)) == $past(w_q)));

    // R4
    home_sends_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_valid && mig_to_native && away_o) |=> (xfer_kind == 2'd3 && xfer_mask == $past(w_q)));

    // R5
    spr_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_spr);
endmodule

// File: tb/mig_mask_ctrl_tb.sv
module mig_mask_ctrl_tb;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mig_valid, mig_to_native, instr_valid;
    logic [N-1:0]  pred_mask, rd_mask, wr_mask;
    logic          xfer_valid, xfer_spr, away_o, home_req, regmiss;
    logic [1:0]    xfer_kind;
    logic [N-1:0]  xfer_mask, vmask_o, wmask_o;
    logic [IW-1:0] regmiss_idx;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    mig_mask_ctrl #(.NREG(N)) u_dut (
        .clk, .rst_n, .mig_valid, .mig_to_native, .pred_mask,
        .instr_valid, .rd_mask, .wr_mask, .xfer_valid, .xfer_kind,
        .xfer_mask, .xfer_spr, .vmask_o, .wmask_o, .away_o, .home_req,
        .regmiss, .regmiss_idx
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, pass one rising edge, return at the next falling edge
    task automatic step(logic mv, logic mn, logic [N-1:0] pm, logic iv,
                        logic [N-1:0] rd, logic [N-1:0] wr);
        mig_valid = mv; mig_to_native = mn; pred_mask = pm;
        instr_valid = iv; rd_mask = rd; wr_mask = wr;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, '0, 0, '0, '0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v, wt, nv;
        int lo;
        rst_n = 0;
        mig_valid = 0; mig_to_native = 0; pred_mask = '0;
        instr_valid = 0; rd_mask = '0; wr_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 vmask", 32'(vmask_o), 32'hFF);
        chk("R1 wmask", 32'(wmask_o), 0);
        chk("R1 quiet", {28'd0, xfer_valid, regmiss, away_o, home_req}, 0);

        // R9: native instruction touching everything, and a request to native
        step(0, 0, '0, 1, 8'hFF, 8'hFF);
        chk("R9 no miss at native", 32'(regmiss), 0);
        step(1, 1, 8'h0F, 0, '0, '0);
        chk("R9 no xfer to native", 32'(xfer_valid), 0);
        chk("R9 still native", 32'(away_o), 0);

        for (int i = 0; i < 256; i++) begin
            v  = N'(i);
            wt = v & N'(i * 8'h5B + 8'h31);
            nv = ~v;
            step(1, 0, v, 0, '0, '0);
            chk("R2 valid", 32'(xfer_valid), 1);
            chk("R2 kind", 32'(xfer_kind), 1);
            chk("R2 mask", 32'(xfer_mask), 32'(v));
            chk("R5 spr out", 32'(xfer_spr), 1);
            chk("R2 vmask", 32'(vmask_o), 32'(v));
            chk("R2 wmask", 32'(wmask_o), 0);
            chk("R2 away", 32'(away_o), 1);
            step(0, 0, nv, 1, v, wt);
            chk("R6 no miss", 32'(regmiss), 0);
            chk("R6 wmask", 32'(wmask_o), 32'(wt));
            chk("R5 idle", {29'd0, xfer_valid, xfer_spr, |xfer_mask}, 0);
            // hop with bogus predictor and an overlapping out-of-mask instruction
            step(1, 0, nv, 1, nv, 8'hFF);
            chk("R3 kind", 32'(xfer_kind), 2);
            chk("R3 mask", 32'(xfer_mask), 32'(v));
            chk("R11 no miss", 32'(regmiss), 0);
            chk("R11 wmask", 32'(wmask_o), 32'(wt));
            chk("R3 vmask", 32'(vmask_o), 32'(v));
            if (v != 8'hFF) begin
                lo = 0;
                for (int b = N - 1; b >= 0; b--) if (nv[b]) lo = b;
                step(0, 0, '0, 1, nv, 8'hFF);
                chk("R7 pulse", 32'(regmiss), 1);
                chk("R7 home_req", 32'(home_req), 1);
                chk("R7 write dropped", 32'(wmask_o), 32'(wt));
                chk("R8 idx", 32'(regmiss_idx), 32'(lo));
                step(0, 0, '0, 1, 8'hFF, 8'hFF);
                chk("R10 no repeat", 32'(regmiss), 0);
                chk("R10 wmask", 32'(wmask_o), 32'(wt));
                step(1, 0, 8'hFF, 0, '0, '0);
                chk("R10 no hop", 32'(xfer_valid), 0);
                chk("R10 stays", 32'(home_req), 1);
                chk("R8 idx held", 32'(regmiss_idx), 32'(lo));
            end
            step(1, 1, 8'hAA, 0, '0, '0);
            chk("R4 kind", 32'(xfer_kind), 3);
            chk("R4 mask", 32'(xfer_mask), 32'(wt));
            chk("R5 spr home", 32'(xfer_spr), 1);
            chk("R4 vmask", 32'(vmask_o), 32'hFF);
            chk("R4 wmask", 32'(wmask_o), 0);
            chk("R4 native", {30'd0, away_o, home_req}, 0);
        end
        idle();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule